// File: doc/BRIEF.md
# Prioritized Interrupt Acceptance Controller

This block gathers interrupt requests from several classes of source, picks the one with the highest priority, and decides whether the CPU should take it. The classes are:

- a non-maskable interrupt input that is detected on its rising edge;
- two fixed-priority sources, one for a break unit and one for a debug port;
- an encoded 4-bit external level code;
- a set of IRQ lines and a set of on-chip peripheral lines, each with a programmable 4-bit priority.

Priorities lie on a 17-step scale, from 0 (lowest) to 16 (highest). The non-maskable input is the only source at level 16. The block compares the winning level with the CPU's current 4-bit mask.

When the winner is taken, the block raises a one-cycle accept pulse. With the pulse it gives the winner's source ID, its vector number and the mask value the CPU must load. It then waits for an acknowledge before it can accept again. Saving CPU state, fetching the vector and any pipeline effects belong to the CPU.

Top module: `intc_accept`

## Requirements
- R1: The non-maskable source has level 16 and is accepted whatever the mask holds. Its acceptance reports a new mask of 15.
- R2: The break source and the debug source each have fixed level 15 while their request lines are high.
- R3: The external code gives its own value (1 to 15) as a request level. A code of 0 means no request.
- R4: Each IRQ and peripheral line uses a 4-bit priority field. The fields reset to 0. A write with `cfg_we` high loads `cfg_lvl` into field `cfg_idx` (IRQ lines first, then peripheral lines) and is used from the next cycle. Writes to an index beyond the last field are ignored.
- R5: A request other than the non-maskable one is accepted only when its level is strictly greater than `cpu_mask`.
- R6: A line whose priority field is 0 is never accepted.
- R7: On acceptance of any source other than the non-maskable one, `acc_mask` equals the accepted level.
- R8: The pending request with the highest level wins. Among equal levels, the lowest source ID wins. The IDs are: 0 non-maskable, 1 break, 2 debug, 3 external code, 4 upward for IRQ lines, then the peripheral lines.
- R9: `acc_vec` equals 64 plus the accepted source ID.
- R10: `accept` is high for exactly one cycle, one clock edge after the inputs that caused it were sampled. No further acceptance happens until `ack` has been sampled high after that pulse.
- R11: A rising edge on `nmi_in` is latched as pending, which gives acceptance two edges after the rise. The pending state is cleared only by the `ack` that follows its own acceptance, and a level held high causes no second acceptance. All other sources are evaluated live each cycle.
- R12: While and right after reset, `accept` is low and the reported ID, vector and mask are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_in | input | 1 | Non-maskable request, rising-edge detected |
| brk_req | input | 1 | Break unit request, fixed level 15 |
| dbg_req | input | 1 | Debug port request, fixed level 15 |
| ext_code | input | 4 | Encoded external level, 0 = none |
| irq_req | input | N_IRQ | IRQ request lines |
| per_req | input | N_PER | Peripheral request lines |
| cpu_mask | input | 4 | Current CPU interrupt mask |
| ack | input | 1 | Acknowledge of the last acceptance |
| cfg_we | input | 1 | Priority field write enable |
| cfg_idx | input | $clog2(N_IRQ+N_PER) | Priority field index |
| cfg_lvl | input | 4 | Priority value to write |
| accept | output | 1 | One-cycle acceptance pulse |
| acc_id | output | $clog2(N_IRQ+N_PER+4) | Accepted source ID |
| acc_vec | output | VEC_W | Accepted vector number |
| acc_mask | output | 4 | Mask value to load |

## Verification
Level sources, the external code and the mask are sampled at one edge, and their acceptance shows up after that same edge. A rising edge on `nmi_in` needs one extra edge because it first passes through the pending latch. A priority write changes arbitration from the cycle after the write edge, and an `ack` re-opens acceptance for the inputs sampled at the edge after it. The bench drives on the falling edge. Before each rising edge it updates a reference model with exactly these latencies, then compares every output at the next falling edge, so each expectation lines up with the edge that produces it.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int LVL_W = 5;
    typedef logic [LVL_W-1:0] lvl_t;

    localparam lvl_t LVL_NMI   = 5'd16;
    localparam lvl_t LVL_FIXED = 5'd15;
    localparam lvl_t LVL_NONE  = 5'd0;

    localparam int ID_NMI        = 0;
    localparam int ID_BRK        = 1;
    localparam int ID_DBG        = 2;
    localparam int ID_EXT        = 3;
    localparam int ID_FIRST_PROG = 4;

    // mask to load after acceptance: top level saturates to 15
    function automatic logic [3:0] mask_after(lvl_t l);
        return (l == LVL_NMI) ? 4'hF : l[3:0];
    endfunction
endpackage

// File: rtl/intc_prio_regs.sv
module intc_prio_regs #(
    parameter int N_FIELD = 12,
    parameter int IW      = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   we,
    input  logic [IW-1:0]          idx,
    input  logic [3:0]             data,
    output logic [N_FIELD-1:0][3:0] lvl
);
    always_ff @(posedge clk) begin
        if (rst) begin
            lvl <= '0;
        end else if (we && (int'(idx) < N_FIELD)) begin
            lvl[idx] <= data;
        end
    end
endmodule

// File: rtl/intc_req_collect.sv
module intc_req_collect
    import intc_pkg::*;
#(
    parameter int N_IRQ = 4,
    parameter int N_PER = 8,
    parameter int NSRC  = ID_FIRST_PROG + N_IRQ + N_PER
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          nmi_in,
    input  logic                          nmi_clr,
    input  logic                          brk_req,
    input  logic                          dbg_req,
    input  logic [3:0]                    ext_code,
    input  logic [N_IRQ-1:0]              irq_req,
    input  logic [N_PER-1:0]              per_req,
    input  logic [N_IRQ+N_PER-1:0][3:0]   prio,
    output lvl_t [NSRC-1:0]               lvls
);
    logic nmi_q, nmi_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_q    <= 1'b0;
            nmi_pend <= 1'b0;
        end else begin
            nmi_q <= nmi_in;
            if (nmi_in && !nmi_q) begin
                nmi_pend <= 1'b1;
            end else if (nmi_clr) begin
                nmi_pend <= 1'b0;
            end
        end
    end

    assign lvls[ID_NMI] = nmi_pend ? LVL_NMI : LVL_NONE;
    assign lvls[ID_BRK] = brk_req ? LVL_FIXED : LVL_NONE;
    assign lvls[ID_DBG] = dbg_req ? LVL_FIXED : LVL_NONE;
    assign lvls[ID_EXT] = {1'b0, ext_code};

    for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
        assign lvls[ID_FIRST_PROG+i] = irq_req[i] ? {1'b0, prio[i]} : LVL_NONE;
    end
    for (genvar j = 0; j < N_PER; j++) begin : g_per
        assign lvls[ID_FIRST_PROG+N_IRQ+j] = per_req[j] ? {1'b0, prio[N_IRQ+j]} : LVL_NONE;
    end
endmodule

// File: rtl/intc_prio_select.sv
module intc_prio_select
    import intc_pkg::*;
#(
    parameter int NSRC = 16,
    parameter int IDW  = 4
) (
    input  lvl_t [NSRC-1:0] lvls,
    output logic [IDW-1:0]  win_id,
    output lvl_t            win_lvl
);
    // strict compare keeps the lowest index on equal levels
    always_comb begin
        win_id  = '0;
        win_lvl = LVL_NONE;
        for (int i = 0; i < NSRC; i++) begin
            if (lvls[i] > win_lvl) begin
                win_lvl = lvls[i];
                win_id  = IDW'(i);
            end
        end
    end
endmodule

// File: rtl/intc_accept.sv
module intc_accept
    import intc_pkg::*;
#(
    parameter int N_IRQ    = 4,
    parameter int N_PER    = 8,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 64,
    localparam int N_PROG  = N_IRQ + N_PER,
    localparam int NSRC    = ID_FIRST_PROG + N_PROG,
    localparam int IDW     = $clog2(NSRC),
    localparam int CIW     = $clog2(N_PROG)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             nmi_in,
    input  logic             brk_req,
    input  logic             dbg_req,
    input  logic [3:0]       ext_code,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_PER-1:0] per_req,
    input  logic [3:0]       cpu_mask,
    input  logic             ack,
    input  logic             cfg_we,
    input  logic [CIW-1:0]   cfg_idx,
    input  logic [3:0]       cfg_lvl,
    output logic             accept,
    output logic [IDW-1:0]   acc_id,
    output logic [VEC_W-1:0] acc_vec,
    output logic [3:0]       acc_mask
);
    logic [N_PROG-1:0][3:0] prio;
    lvl_t [NSRC-1:0]        lvls;
    logic [IDW-1:0]         win_id;
    lvl_t                   win_lvl;
    logic                   busy, last_nmi, go, nmi_clr;

    intc_prio_regs #(.N_FIELD(N_PROG), .IW(CIW)) u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .idx(cfg_idx), .data(cfg_lvl), .lvl(prio)
    );

    intc_req_collect #(.N_IRQ(N_IRQ), .N_PER(N_PER), .NSRC(NSRC)) u_req (
        .clk(clk), .rst(rst), .nmi_in(nmi_in), .nmi_clr(nmi_clr),
        .brk_req(brk_req), .dbg_req(dbg_req), .ext_code(ext_code),
        .irq_req(irq_req), .per_req(per_req), .prio(prio), .lvls(lvls)
    );

    intc_prio_select #(.NSRC(NSRC), .IDW(IDW)) u_sel (
        .lvls(lvls), .win_id(win_id), .win_lvl(win_lvl)
    );

    assign go      = !busy && (win_lvl > {1'b0, cpu_mask});
    assign nmi_clr = ack && busy && last_nmi;

    always_ff @(posedge clk) begin
        if (rst) begin
            accept   <= 1'b0;
            acc_id   <= '0;
            acc_vec  <= '0;
            acc_mask <= '0;
            busy     <= 1'b0;
            last_nmi <= 1'b0;
        end else begin
            accept <= go;
            if (go) begin
                acc_id   <= win_id;
                acc_vec  <= VEC_W'(VEC_BASE) + VEC_W'(win_id);
                acc_mask <= mask_after(win_lvl);
                busy     <= 1'b1;
                last_nmi <= (win_lvl == LVL_NMI);
            end else if (ack) begin
                busy <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/intc_accept_chk.sv
module intc_accept_chk #(
    parameter int IDW = 4
) (
    input logic           clk,
    input logic           rst,
    input logic [3:0]     cpu_mask,
    input logic           accept,
    input logic [IDW-1:0] acc_id,
    input logic [3:0]     acc_mask
);
    p_single_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        accept |=> !accept);

    p_above_mask_r5: assert property (@(posedge clk) disable iff (rst)
        (accept && acc_id != '0) |-> (acc_mask > $past(cpu_mask)));

    p_nmi_mask_r1: assert property (@(posedge clk) disable iff (rst)
        (accept && acc_id == '0) |-> (acc_mask == 4'hF));

    p_nonzero_level_r6: assert property (@(posedge clk) disable iff (rst)
        accept |-> (acc_mask != 4'h0));

    p_quiet_after_reset_r12: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !accept);
endmodule

bind intc_accept intc_accept_chk #(.IDW(IDW)) u_chk (
    .clk(clk), .rst(rst), .cpu_mask(cpu_mask), .accept(accept),
    .acc_id(acc_id), .acc_mask(acc_mask)
);

// File: tb/sim_intc_accept.sv
`timescale 1ns/1ps
module sim_intc_accept;
    localparam int N_IRQ = 4;
    localparam int N_PER = 8;
    localparam int N_PROG = N_IRQ + N_PER;
    localparam int NSRC = 4 + N_PROG;
    localparam int IDW = $clog2(NSRC);
    localparam int CIW = $clog2(N_PROG);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic nmi_in = 0, brk_req = 0, dbg_req = 0, ack = 0, cfg_we = 0;
    logic [3:0] ext_code = 0, cpu_mask = 0, cfg_lvl = 0;
    logic [N_IRQ-1:0] irq_req = 0;
    logic [N_PER-1:0] per_req = 0;
    logic [CIW-1:0] cfg_idx = 0;
    logic accept;
    logic [IDW-1:0] acc_id;
    logic [7:0] acc_vec;
    logic [3:0] acc_mask;

    int checks = 0, errors = 0;
    int m_prio [N_PROG];
    bit m_pend, m_nmi_q, m_busy, m_last_nmi;

    always #4 clk = ~clk;

    intc_accept u0 (
        .clk(clk), .rst(rst), .nmi_in(nmi_in), .brk_req(brk_req), .dbg_req(dbg_req),
        .ext_code(ext_code), .irq_req(irq_req), .per_req(per_req), .cpu_mask(cpu_mask),
        .ack(ack), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_lvl(cfg_lvl),
        .accept(accept), .acc_id(acc_id), .acc_vec(acc_vec), .acc_mask(acc_mask)
    );

    function automatic int src_level(int id);
        if (id == 0) return m_pend ? 16 : 0;
        if (id == 1) return brk_req ? 15 : 0;
        if (id == 2) return dbg_req ? 15 : 0;
        if (id == 3) return int'(ext_code);
        if (id < 4 + N_IRQ) return irq_req[id-4] ? m_prio[id-4] : 0;
        return per_req[id-4-N_IRQ] ? m_prio[id-4] : 0;
    endfunction

    // compute expectation for this cycle, advance model, wait, compare
    task automatic step(string tag);
        int best_id = 0, best_lvl = 0;
        bit exp_acc;
        for (int i = 0; i < NSRC; i++) begin
            if (src_level(i) > best_lvl) begin
                best_lvl = src_level(i);
                best_id = i;
            end
        end
        exp_acc = !m_busy && (best_lvl > int'(cpu_mask));
        if (nmi_in && !m_nmi_q) m_pend = 1;
        else if (ack && m_busy && m_last_nmi) m_pend = 0;
        m_nmi_q = nmi_in;
        if (exp_acc) begin
            m_busy = 1;
            m_last_nmi = (best_id == 0);
        end else if (ack) m_busy = 0;
        if (cfg_we && int'(cfg_idx) < N_PROG) m_prio[cfg_idx] = int'(cfg_lvl);
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (exp_acc) begin
            if (!(accept && int'(acc_id) == best_id && int'(acc_vec) == 64 + best_id &&
                  int'(acc_mask) == (best_lvl == 16 ? 15 : best_lvl))) begin
                errors++;
                $display("FAIL %s: got acc=%0b id=%0d vec=%0d mask=%0d, expected acc=1 id=%0d vec=%0d mask=%0d",
                         tag, accept, acc_id, acc_vec, acc_mask, best_id, 64 + best_id,
                         (best_lvl == 16 ? 15 : best_lvl));
            end
        end else if (accept) begin
            errors++;
            $display("FAIL %s: got acc=1 id=%0d, expected acc=0", tag, acc_id);
        end
    endtask

    task automatic clear_inputs();
        nmi_in = 0; brk_req = 0; dbg_req = 0; ext_code = 0; irq_req = 0; per_req = 0;
        ack = 0; cfg_we = 0;
    endtask

    task automatic do_ack(string tag);
        clear_inputs();
        ack = 1;
        step(tag);
        ack = 0;
    endtask

    task automatic write_prio(int idx, int lvl);
        cfg_we = 1; cfg_idx = CIW'(idx); cfg_lvl = 4'(lvl);
        step("R4 write");
        cfg_we = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got no finish, expected end of run");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int seed = 32'h5EED;
        void'($urandom(seed));
        foreach (m_prio[k]) m_prio[k] = 0;
        m_pend = 0; m_nmi_q = 0; m_busy = 0; m_last_nmi = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12: reset state
        checks++;
        if (accept || acc_id != 0 || acc_vec != 0 || acc_mask != 0) begin
            errors++;
            $display("FAIL R12: got acc=%0b id=%0d vec=%0d mask=%0d, expected all 0",
                     accept, acc_id, acc_vec, acc_mask);
        end
        rst = 0;
        step("R12 first cycle");

        // R2/R5: fixed 15 not above mask 15, then above mask 14
        cpu_mask = 15; brk_req = 1; step("R2 R5 equal mask");
        cpu_mask = 14; step("R2 R7 break accept");
        step("R10 held while busy");
        do_ack("R10 ack");
        cpu_mask = 14; dbg_req = 1; brk_req = 1; step("R8 break over debug tie");
        do_ack("R10 ack");

        // R3: external code
        cpu_mask = 0; ext_code = 0; step("R3 code zero");
        ext_code = 5; cpu_mask = 4; step("R3 ext accept");
        do_ack("R10 ack");

        // R6: level zero never accepted
        cpu_mask = 0; irq_req = 4'b0001; step("R6 level zero");
        clear_inputs();

        // R4/R8: ties and higher levels among programmable lines
        write_prio(1, 9); write_prio(N_IRQ + 2, 9); write_prio(N_PROG + 1, 15);
        cpu_mask = 3; irq_req = 4'b0010; per_req = 8'b0000_0100; step("R8 tie lowest id");
        do_ack("R10 ack");
        write_prio(N_IRQ + 2, 10);
        cpu_mask = 3; irq_req = 4'b0010; per_req = 8'b0000_0100; step("R8 higher level");
        do_ack("R9 ack");

        // R1/R11: NMI through full mask, held high gives one acceptance
        cpu_mask = 15; nmi_in = 1; step("R11 nmi latch");
        step("R1 nmi accept");
        step("R11 busy");
        ack = 1; step("R11 ack clear"); ack = 0;
        repeat (3) step("R11 no second accept");
        nmi_in = 0; step("R11 nmi low");

        // random phase
        for (int n = 0; n < 4000; n++) begin
            nmi_in   = ($urandom_range(0, 15) == 0);
            brk_req  = ($urandom_range(0, 9) == 0);
            dbg_req  = ($urandom_range(0, 9) == 0);
            ext_code = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 15)) : 4'd0;
            irq_req  = N_IRQ'($urandom) & N_IRQ'($urandom);
            per_req  = N_PER'($urandom) & N_PER'($urandom);
            cpu_mask = 4'($urandom_range(0, 15));
            ack      = ($urandom_range(0, 2) == 0);
            cfg_we   = ($urandom_range(0, 7) == 0);
            cfg_idx  = CIW'($urandom_range(0, (1 << CIW) - 1));
            cfg_lvl  = 4'($urandom_range(0, 15));
            step("R5 R7 R8 R9 random");
        end
        clear_inputs();
        step("R10 end");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule